// File: doc/BRIEF.md
# Stack Pointer Offset Tracker

This front-end stage sits between instruction decode and the execution core and rewrites stack operations. Every push, pop, call and return still turns into one memory micro-op, but the address it carries is the architectural stack pointer plus a small signed offset held inside the stage. The stack-pointer arithmetic those instructions imply is never issued as a micro-op. The offset only moves in the local register.

The real stack pointer is brought up to date by one synchronising micro-op, which adds the accumulated offset to it. The stage inserts this micro-op in three cases: when the offset would leave its field, when an interrupt or exception is taken, and in front of any operation that reads or writes the stack pointer directly.

When the stage inserts a synchronising micro-op, it holds its input for that one cycle and clears the offset. The held operation then goes through on the next cycle. The output is a single micro-op lane with a valid flag and no back-pressure.

Top module: `spo_engine`

## Requirements
- R1: After reset the offset is zero, `in_ready` is high, and `uop_valid` is low while there is no input and no event. Every offset value is a multiple of 8.
- R2: A push (op code 1) or a call (op code 3) that is accepted produces a store (kind 1) whose offset is the current offset minus 8. The offset then becomes that value.
- R3: A pop (op code 2) or a return (op code 4) that is accepted produces a load (kind 2) whose offset is the current offset. The offset then grows by 8.
- R4: Any other operation (op code 0, or op code 5 when no sync is due) is passed through as kind 0 with offset field 0, and the stored offset does not change. For kinds 0, 1 and 2 the tag is copied from `in_tag`. For kind 3 the tag is 0.
- R5: An operation that touches the stack pointer directly (op code 5), presented while the offset is nonzero, produces a sync (kind 3) that carries the whole offset. During that cycle `in_ready` is low. The operation passes through on the following cycle.
- R6: A pulse on `evt_irq` while the offset is nonzero produces a sync that carries the offset. The input is held for that cycle, even if an operation is waiting.
- R7: The offset stays within -128 to +120. If a push or call would take it below -128, or a pop or return would take it above +120, a sync is emitted first. The held operation then issues from offset 0: a store at -8 or a load at 0.
- R8: The cycle after a sync has been emitted, the offset is zero.
- R9: When the offset is zero, no sync is ever emitted. An `evt_irq` pulse or an op code 5 is then handled as if no trigger were present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded operation present |
| in_ready | output | 1 | Stage accepts the operation this cycle |
| in_op | input | 3 | Operation code: 0 other, 1 push, 2 pop, 3 call, 4 return, 5 direct stack-pointer access |
| in_tag | input | TAG_W | Payload carried with the operation |
| evt_irq | input | 1 | Interrupt or exception taken this cycle |
| uop_valid | output | 1 | A micro-op is emitted this cycle |
| uop_kind | output | 2 | 0 pass-through, 1 store, 2 load, 3 sync |
| uop_off | output | OFF_W | Signed byte offset from the architectural stack pointer (sync: amount to add) |
| uop_tag | output | TAG_W | Payload of the emitted micro-op |

## Verification
The checker tests several properties on every cycle. The offset must stay in range and stay aligned, and it must be zero one cycle after any sync. A store must leave the offset equal to its own address field, and a load must leave it 8 above. A sync must never carry a zero amount, and it must always coincide with a stalled input. Other behaviour can only be shown by bench scenarios: which trigger caused a sync, whether the held operation really issues from the cleared offset, that triggers have no effect at offset zero, and that tags are carried through correctly. The bench covers these by running long push and pop chains up to both ends of the range, and by mixing random event pulses into the operation stream.

// File: rtl/spo_pkg.sv
package spo_pkg;
  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_SPACC = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    UK_PASS  = 2'd0,
    UK_STORE = 2'd1,
    UK_LOAD  = 2'd2,
    UK_SYNC  = 2'd3
  } uop_e;

  // offset after one stack step; down = toward lower addresses
  function automatic int step_off(input int cur, input bit down, input int step);
    return down ? cur - step : cur + step;
  endfunction

  // true when a value falls outside the offset field's usable range
  function automatic bit outside(input int v, input int lo, input int hi);
    return (v < lo) || (v > hi);
  endfunction
endpackage

// File: rtl/spo_classify.sv
module spo_classify
  import spo_pkg::*;
(
  input  logic [2:0] op,
  output logic       is_down,
  output logic       is_up,
  output logic       is_sp_touch
);
  always_comb begin
    is_down     = 1'b0;
    is_up       = 1'b0;
    is_sp_touch = 1'b0;
    case (op_e'(op))
      OP_PUSH, OP_CALL: is_down     = 1'b1;
      OP_POP,  OP_RET:  is_up       = 1'b1;
      OP_SPACC:         is_sp_touch = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/spo_offset_reg.sv
module spo_offset_reg #(
  parameter int OFF_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    upd,
  input  logic signed [OFF_W-1:0] nxt,
  output logic signed [OFF_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (upd) q <= nxt;
  end
endmodule

// File: rtl/spo_engine.sv
module spo_engine
  import spo_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter int STEP  = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             evt_irq,
  output logic             uop_valid,
  output logic [1:0]       uop_kind,
  output logic [OFF_W-1:0] uop_off,
  output logic [TAG_W-1:0] uop_tag
);
  localparam int OFF_LO = -(2 ** (OFF_W - 1));
  localparam int OFF_HI = (2 ** (OFF_W - 1)) - STEP;

  logic is_down, is_up, is_sp_touch;
  logic signed [OFF_W-1:0] off_q;
  logic signed [OFF_W-1:0] off_nxt;
  int   cur_i, nxt_i;
  logic ovf_hit;     // next step would leave the field
  logic sync_need;   // sync micro-op emitted this cycle
  logic fire_in;     // input accepted this cycle
  logic off_upd;

  spo_classify u_cls (
    .op          (in_op),
    .is_down     (is_down),
    .is_up       (is_up),
    .is_sp_touch (is_sp_touch)
  );

  always_comb begin
    cur_i   = int'(off_q);
    nxt_i   = step_off(cur_i, is_down, STEP);
    ovf_hit = (is_down || is_up) && outside(nxt_i, OFF_LO, OFF_HI);
    off_nxt = OFF_W'(nxt_i);
  end

  assign sync_need = (off_q != '0) &&
                     (evt_irq || (in_valid && (is_sp_touch || ovf_hit)));
  assign in_ready  = !sync_need;
  assign fire_in   = in_valid && in_ready;
  assign off_upd   = fire_in && (is_down || is_up);

  spo_offset_reg #(.OFF_W(OFF_W)) u_off (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sync_need),
    .upd   (off_upd),
    .nxt   (off_nxt),
    .q     (off_q)
  );

  always_comb begin
    uop_valid = 1'b0;
    uop_kind  = UK_PASS;
    uop_off   = '0;
    uop_tag   = '0;
    if (sync_need) begin
      uop_valid = 1'b1;
      uop_kind  = UK_SYNC;
      uop_off   = off_q;
    end else if (fire_in) begin
      uop_valid = 1'b1;
      uop_tag   = in_tag;
      if (is_down) begin
        uop_kind = UK_STORE;
        uop_off  = off_nxt;
      end else if (is_up) begin
        uop_kind = UK_LOAD;
        uop_off  = off_q;
      end
    end
  end
endmodule

// File: rtl/spo_checker.sv
module spo_checker #(
  parameter int OFF_W = 8,
  parameter int STEP  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    uop_valid,
  input logic [1:0]              uop_kind,
  input logic signed [OFF_W-1:0] uop_off,
  input logic signed [OFF_W-1:0] off_q,
  input logic                    sync_need
);
  localparam int LO = -(2 ** (OFF_W - 1));
  localparam int HI = (2 ** (OFF_W - 1)) - STEP;

  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(off_q) % STEP) == 0);

  assert_store_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == 2'd1) |=> off_q == $past(uop_off));

  assert_load_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == 2'd2) |=> off_q == OFF_W'($past(uop_off) + STEP));

  assert_pass_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == 2'd0) |=> $stable(off_q));

  assert_sync_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == 2'd3) |-> !in_ready);

  assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(off_q) >= LO) && (int'(off_q) <= HI));

  assert_sync_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_need |=> off_q == '0);

  assert_no_zero_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == 2'd3) |-> uop_off != '0);
endmodule

bind spo_engine spo_checker #(.OFF_W(OFF_W), .STEP(STEP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .uop_valid (uop_valid),
  .uop_kind  (uop_kind),
  .uop_off   (uop_off),
  .off_q     (off_q),
  .sync_need (sync_need)
);

// File: tb/sim_spo_engine.sv
`timescale 1ns/1ps
module sim_spo_engine;
  localparam int OFF_W = 8;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_op = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic evt_irq = 1'b0;
  logic in_ready, uop_valid;
  logic [1:0] uop_kind;
  logic [OFF_W-1:0] uop_off;
  logic [TAG_W-1:0] uop_tag;

  int total = 0, bad = 0;
  int m_off = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spo_engine #(.OFF_W(OFF_W), .STEP(8), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_tag(in_tag), .evt_irq(evt_irq),
    .uop_valid(uop_valid), .uop_kind(uop_kind), .uop_off(uop_off), .uop_tag(uop_tag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench model: stack direction and range limits restated from the requirements.
  function automatic int sp_move(input int op);
    if (op == 1 || op == 3) return -8;
    if (op == 2 || op == 4) return 8;
    return 0;
  endfunction

  // One cycle: drive, compare against the model, advance the model. Returns accepted.
  task automatic cyc(input bit v, input int op, input int tag, input bit irq, output bit acc);
    int mv, e_kind, e_off, e_tag;
    bit e_sync, e_valid, e_rdy;
    string req;
    @(negedge clk);
    in_valid = v; in_op = 3'(op); in_tag = TAG_W'(tag); evt_irq = irq;
    mv = sp_move(op);
    e_sync = 0; req = "R4";
    if (m_off != 0) begin
      if (irq) begin e_sync = 1; req = "R6"; end
      else if (v && op == 5) begin e_sync = 1; req = "R5"; end
      else if (v && mv != 0 && (m_off + mv < -128 || m_off + mv > 120)) begin
        e_sync = 1; req = "R7";
      end
    end else if (irq || (v && op == 5)) req = "R9";
    e_rdy = !e_sync;
    e_valid = e_sync || v;
    e_tag = e_sync ? 0 : tag;
    if (e_sync) begin e_kind = 3; e_off = m_off; end
    else if (mv < 0) begin e_kind = 1; e_off = m_off - 8; req = "R2"; end
    else if (mv > 0) begin e_kind = 2; e_off = m_off; req = "R3"; end
    else begin e_kind = 0; e_off = 0; end
    #1;
    check(req, "in_ready", int'(in_ready), int'(e_rdy));
    check(req, "uop_valid", int'(uop_valid), int'(e_valid));
    if (e_valid) begin
      check(req, "uop_kind", int'(uop_kind), e_kind);
      check(req, "uop_off", int'($signed(uop_off)), e_off);
      check(req, "uop_tag", int'(uop_tag), e_tag);
    end
    acc = v && e_rdy;
    if (e_sync) m_off = 0;
    else if (acc) m_off = m_off + mv;
  endtask

  // present an op until accepted
  task automatic issue(input int op, input int tag);
    bit a;
    a = 0;
    while (!a) cyc(1'b1, op, tag, 1'b0, a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    int unsigned seed;
    int hold_op, hold_tag;
    bit hold;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state, idle
    cyc(1'b0, 0, 0, 1'b0, a);
    // R9: triggers at zero offset do nothing
    cyc(1'b0, 0, 0, 1'b1, a);
    cyc(1'b1, 5, 8'h11, 1'b1, a);
    // R1/R2: first push lands at -8
    issue(1, 8'h21);
    // R6: interrupt with nonzero offset, op waiting
    cyc(1'b1, 1, 8'h22, 1'b1, a);
    check("R8", "store after irq sync", int'(a), 0);
    issue(1, 8'h22);
    // R5: explicit stack-pointer access
    issue(3, 8'h23);
    issue(5, 8'h24);
    // R7: run pushes down to -128, then one more
    for (int i = 0; i < 20; i++) issue((i % 2) ? 1 : 3, i);
    // R7: pops upward past +120
    for (int i = 0; i < 40; i++) issue((i % 2) ? 2 : 4, 100 + i);
    issue(0, 8'h55);
    // random mix, holding ops until accepted
    hold = 0; hold_op = 0; hold_tag = 0;
    for (int n = 0; n < 4000; n++) begin
      bit v, irq;
      if (!hold) begin
        hold_op = int'($urandom % 6);
        hold_tag = int'($urandom % 256);
        v = ($urandom % 4) != 0;
      end else v = 1;
      irq = ($urandom % 16) == 0;
      cyc(v, hold_op, hold_tag, irq, a);
      hold = v && !a;
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule